// File: doc/BRIEF.md
# Fractional Audio Master and Bit Clock Generator

This block turns a fast system clock into two slower audio clocks. A fractional rate stage adds a numerator X to an accumulator on every system clock cycle. Each time the sum reaches the denominator Y it emits a one-cycle strobe and subtracts Y. A halving stage toggles the master clock on every strobe, so the master clock runs at `clk * X / Y / 2`. A cascaded integer stage divides the master clock by a programmable value plus one to form the bit clock. Every output is a register or a strobe in the system clock domain, so no new clock net is created. Downstream logic can use the strobes as clock enables.

The ratio is presented as one packed word: Y in bits 7:0 and X in bits 15:8. A zero operand, or X larger than Y, stops both clocks and holds them low. Any change to the ratio word, the bit divider value or the enable input drops the block to its idle state for one cycle. Counting then restarts from a clean zero, so no partial or runt period is produced.

Top module: `frac_mclk_gen`

## Requirements
- R1: While `rst_n` is low, `mclk_tick`, `mclk_out`, `bclk_tick` and `bclk_out` are all 0.
- R2: Count the cycles of an uninterrupted valid run from n = 1. `mclk_tick` is high in run cycle n exactly when floor(n·X/Y) > floor((n-1)·X/Y). When X equals Y it is high in every run cycle.
- R3: `mclk_out` starts low at the start of a run. It inverts on the clock edge that ends each cycle in which `mclk_tick` is high, and holds its value otherwise. This gives a master clock at clk·X/(2·Y).
- R4: `bclk_tick` is high only together with `mclk_tick`, on every (D+1)-th master tick of a run, where D is the 6-bit `bit_div` value. `bclk_out` starts low and inverts on the edge that ends each such cycle, so the bit clock period is D+1 master clock periods.
- R5: `rate_cfg[7:0]` is the denominator Y and `rate_cfg[15:8]` is the numerator X.
- R6: If X = 0 or Y = 0, no tick is produced and both clock outputs are low from the following cycle on.
- R7: If X > Y, the setting is invalid. No tick is produced and both clock outputs are low from the following cycle on.
- R8: While `enable` is low, no tick is produced and both clock outputs are low from the following cycle on.
- R9: In a cycle where `enable`, `rate_cfg` or `bit_div` differs from its value in the previous cycle, no tick is produced and all state is cleared at the next edge. The next cycle counts as run cycle n = 1 of a fresh run. This holds even when a tick would otherwise have fallen in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that the fractional stage divides |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator when high |
| rate_cfg | input | 16 | Ratio word: Y in bits 7:0, X in bits 15:8 |
| bit_div | input | 6 | Bit clock divider D; the bit clock is the master clock divided by D+1 |
| mclk_tick | output | 1 | One-cycle strobe on each master clock edge (fractional overflow) |
| mclk_out | output | 1 | Master clock level, registered |
| bclk_tick | output | 1 | One-cycle strobe on each bit clock edge |
| bclk_out | output | 1 | Bit clock level, registered |

## Verification
Two functions can meet in one cycle.

The first pair is a restart and a fractional overflow. The bench changes the ratio or divider value in a cycle where the running accumulator would have overflowed. It expects no strobe in that cycle, both levels low after the edge, and a fresh count from the next cycle. X = 1, Y = 2 with frequent changes lands restarts on the overflow cycles.

The second pair is a bit clock edge and a master clock edge. They must coincide on every (D+1)-th overflow. The bench computes this from a tick count that is independent of the design's counters. It checks every cycle against a model built from floor arithmetic, with no accumulator in the model.

// File: rtl/frac_clk_pkg.sv
package frac_clk_pkg;

  // Gate decision taken by the configuration guard every cycle.
  typedef enum logic [1:0] {
    GATE_OFF     = 2'd0,  // disabled or illegal ratio
    GATE_RESTART = 2'd1,  // settings moved this cycle, clear everything
    GATE_RUN     = 2'd2   // counting
  } gate_e;

  localparam int unsigned RATE_W_DEF = 8;
  localparam int unsigned DIV_W_DEF  = 6;

endpackage

// File: rtl/frac_cfg_guard.sv
module frac_cfg_guard
  import frac_clk_pkg::*;
#(
  parameter int unsigned RATE_W = RATE_W_DEF,
  parameter int unsigned DIV_W  = DIV_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [RATE_W-1:0] x_val,
  input  logic [RATE_W-1:0] y_val,
  input  logic [DIV_W-1:0]  div_val,
  output gate_e             gate_state,
  output logic              run,
  output logic              cfg_change,
  output logic              cfg_ok
);

  localparam int unsigned SNAP_W = 1 + 2 * RATE_W + DIV_W;

  // Legal ratio: both operands non-zero and numerator not above denominator.
  function automatic logic ratio_legal(input logic [RATE_W-1:0] num,
                                       input logic [RATE_W-1:0] den);
    return (num != '0) && (den != '0) && (num <= den);
  endfunction

  logic [SNAP_W-1:0] snap_cur;
  logic [SNAP_W-1:0] snap_q;

  assign snap_cur = {enable, x_val, y_val, div_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_cur;
  end

  assign cfg_change = (snap_cur != snap_q);
  assign cfg_ok     = enable && ratio_legal(x_val, y_val);

  always_comb begin
    if (!cfg_ok)         gate_state = GATE_OFF;
    else if (cfg_change) gate_state = GATE_RESTART;
    else                 gate_state = GATE_RUN;
  end

  assign run = (gate_state == GATE_RUN);

endmodule

// File: rtl/frac_accum.sv
module frac_accum #(
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] x_val,
  input  logic [RATE_W-1:0] y_val,
  output logic              frac_hit
);

  localparam int unsigned SUM_W = RATE_W + 1;

  function automatic logic [SUM_W-1:0] acc_sum(input logic [RATE_W-1:0] acc,
                                               input logic [RATE_W-1:0] inc);
    return {1'b0, acc} + {1'b0, inc};
  endfunction

  // Residue after an overflow: stays below the denominator.
  function automatic logic [RATE_W-1:0] acc_wrap(input logic [SUM_W-1:0] s,
                                                 input logic [RATE_W-1:0] den);
    logic [SUM_W-1:0] r;
    r = s - {1'b0, den};
    return r[RATE_W-1:0];
  endfunction

  logic [RATE_W-1:0] acc_q;
  logic [SUM_W-1:0]  sum;

  assign sum      = acc_sum(acc_q, x_val);
  assign frac_hit = run && (sum >= {1'b0, y_val});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (!run)     acc_q <= '0;
    else if (frac_hit) acc_q <= acc_wrap(sum, y_val);
    else               acc_q <= sum[RATE_W-1:0];
  end

endmodule

// File: rtl/clk_halver.sv
module clk_halver (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hit,
  output logic level
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    level <= 1'b0;
    else if (!run) level <= 1'b0;
    else if (hit)  level <= ~level;
  end

endmodule

// File: rtl/bit_divider.sv
module bit_divider #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hit,
  input  logic [DIV_W-1:0] div_val,
  output logic             bit_tick,
  output logic             bit_level
);

  logic [DIV_W-1:0] edge_cnt;
  logic             at_limit;

  assign at_limit = (edge_cnt == div_val);
  assign bit_tick = run && hit && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt  <= '0;
      bit_level <= 1'b0;
    end else if (!run) begin
      edge_cnt  <= '0;
      bit_level <= 1'b0;
    end else if (hit) begin
      if (at_limit) begin
        edge_cnt  <= '0;
        bit_level <= ~bit_level;
      end else begin
        edge_cnt  <= edge_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/frac_mclk_gen.sv
module frac_mclk_gen
  import frac_clk_pkg::*;
#(
  parameter int unsigned RATE_W = RATE_W_DEF,
  parameter int unsigned DIV_W  = DIV_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [2*RATE_W-1:0] rate_cfg,
  input  logic [DIV_W-1:0]    bit_div,
  output logic                mclk_tick,
  output logic                mclk_out,
  output logic                bclk_tick,
  output logic                bclk_out
);

  logic [RATE_W-1:0] x_val;
  logic [RATE_W-1:0] y_val;
  gate_e             gate_state;
  logic              run;
  logic              cfg_change;
  logic              cfg_ok;
  logic              frac_hit;

  assign y_val = rate_cfg[RATE_W-1:0];
  assign x_val = rate_cfg[2*RATE_W-1:RATE_W];

  frac_cfg_guard #(.RATE_W(RATE_W), .DIV_W(DIV_W)) guard_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .x_val(x_val), .y_val(y_val), .div_val(bit_div),
    .gate_state(gate_state), .run(run),
    .cfg_change(cfg_change), .cfg_ok(cfg_ok)
  );

  frac_accum #(.RATE_W(RATE_W)) accum_i (
    .clk(clk), .rst_n(rst_n), .run(run),
    .x_val(x_val), .y_val(y_val), .frac_hit(frac_hit)
  );

  clk_halver halver_i (
    .clk(clk), .rst_n(rst_n), .run(run), .hit(frac_hit), .level(mclk_out)
  );

  bit_divider #(.DIV_W(DIV_W)) bitdiv_i (
    .clk(clk), .rst_n(rst_n), .run(run), .hit(frac_hit),
    .div_val(bit_div), .bit_tick(bclk_tick), .bit_level(bclk_out)
  );

  assign mclk_tick = frac_hit;

endmodule

// File: rtl/frac_mclk_gen_chk.sv
module frac_mclk_gen_chk #(
  parameter int unsigned RATE_W = 8,
  parameter int unsigned DIV_W  = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic [2*RATE_W-1:0] rate_cfg,
  input logic [DIV_W-1:0]    bit_div,
  input logic                mclk_tick,
  input logic                mclk_out,
  input logic                bclk_tick,
  input logic                bclk_out,
  input logic                run,
  input logic                cfg_change
);

  logic [RATE_W-1:0] cx;
  logic [RATE_W-1:0] cy;
  assign cy = rate_cfg[RATE_W-1:0];
  assign cx = rate_cfg[2*RATE_W-1:RATE_W];

  AST_BCLK_ON_MCLK: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_tick |-> mclk_tick); // R4

  AST_MCLK_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mclk_tick) |=> (mclk_out != $past(mclk_out))); // R3

  AST_MCLK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !mclk_tick) |=> $stable(mclk_out)); // R3

  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((cx == '0) || (cy == '0)) |-> !mclk_tick); // R6

  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cx > cy) |-> !mclk_tick); // R7

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!mclk_out && !bclk_out)); // R8

  AST_RESTART_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |-> !mclk_tick); // R9

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |=> (!mclk_out && !bclk_out)); // R9

endmodule

bind frac_mclk_gen frac_mclk_gen_chk #(.RATE_W(RATE_W), .DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .rate_cfg(rate_cfg),
  .bit_div(bit_div), .mclk_tick(mclk_tick), .mclk_out(mclk_out),
  .bclk_tick(bclk_tick), .bclk_out(bclk_out), .run(run),
  .cfg_change(cfg_change)
);

// File: tb/frac_mclk_gen_tb_top.sv
`timescale 1ns/1ps
module frac_mclk_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] rate_cfg = '0;
  logic [5:0]  bit_div = '0;
  logic        mclk_tick, mclk_out, bclk_tick, bclk_out;

  always #2.5 clk = ~clk;

  frac_mclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate_cfg(rate_cfg),
    .bit_div(bit_div), .mclk_tick(mclk_tick), .mclk_out(mclk_out),
    .bclk_tick(bclk_tick), .bclk_out(bclk_out)
  );

  typedef struct {
    string    tag;
    logic [3:0] exp; // {mclk_tick, mclk_out, bclk_tick, bclk_out}
  } item_t;

  item_t sb_q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // Reference state: run cycles, ticks seen, divider of the run, last settings.
  int          m_n = 0;
  int          m_hits = 0;
  int          m_div = 0;
  logic [22:0] m_prev = '0;

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs {mtick,mclk,btick,bclk} actual %b expected %b at %0t",
               tag, act, exp, $time);
    end
  endtask

  // Driver: applies settings for a number of cycles and pushes the expectation.
  task automatic drive(input logic en, input int x, input int y, input int d,
                       input int cycles, input string tag);
    for (int c = 0; c < cycles; c++) begin
      item_t it;
      logic [22:0] cur;
      bit chg, ok, run, tk, btk;
      @(negedge clk);
      enable   = en;
      rate_cfg = {x[7:0], y[7:0]};
      bit_div  = d[5:0];
      cur = {en, x[7:0], y[7:0], d[5:0]};
      chg = (cur != m_prev);
      ok  = en && (x != 0) && (y != 0) && (x <= y);
      run = ok && !chg;
      tk = 1'b0;
      btk = 1'b0;
      if (run) begin
        tk  = (((m_n + 1) * x) / y) > ((m_n * x) / y);
        btk = tk && (((m_hits + 1) % (d + 1)) == 0);
      end
      it.tag = tag;
      it.exp = {tk, m_hits[0], btk, 1'(((m_hits / (m_div + 1)) % 2))};
      sb_q.push_back(it);
      if (!run) begin
        m_n = 0;
        m_hits = 0;
      end else begin
        m_n++;
        if (tk) m_hits++;
      end
      m_div  = d;
      m_prev = cur;
    end
  endtask

  // Monitor: compares once outputs have settled after each driven cycle.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, {mclk_tick, mclk_out, bclk_tick, bclk_out}, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: outputs low during reset even with a legal setting applied
    enable = 1'b1;
    rate_cfg = {8'd1, 8'd1};
    repeat (3) begin
      @(negedge clk);
      #1;
      check("R1 reset", {mclk_tick, mclk_out, bclk_tick, bclk_out}, 4'b0000);
    end
    @(negedge clk);
    enable = 1'b0;
    rate_cfg = '0;
    rst_n = 1'b1;

    drive(0, 0, 0, 0, 4, "R8 idle");
    // R2 R3 R4: X = Y ticks every cycle, bit divider of one
    drive(1, 1, 1, 0, 20, "R2 R3 R4 full rate");
    // R5: fields X in high byte, Y in low byte
    drive(1, 3, 8, 2, 200, "R2 R5 3/8 div3");
    drive(1, 5, 7, 5, 200, "R3 R4 5/7 div6");
    drive(1, 255, 255, 63, 300, "R4 max divider");
    drive(1, 1, 255, 1, 1200, "R2 slowest ratio");
    drive(1, 7, 9, 0, 50, "R4 div1");
    // R6: zero operands
    drive(1, 0, 9, 3, 30, "R6 X zero");
    drive(1, 4, 0, 3, 30, "R6 Y zero");
    // R7: X above Y
    drive(1, 2, 3, 1, 20, "R7 before");
    drive(1, 9, 4, 1, 40, "R7 invalid");
    // R8: enable low mid-run
    drive(1, 2, 3, 1, 25, "R8 before");
    drive(0, 2, 3, 1, 20, "R8 disabled");
    drive(1, 2, 3, 1, 25, "R8 resumed");
    // R9: restarts falling on overflow cycles, ratio and divider moves
    for (int k = 0; k < 12; k++) begin
      drive(1, 1, 2, k % 3, 3 + (k % 4), "R9 ratio restart");
      drive(1, 1, 3, k % 3, 2 + (k % 5), "R9 ratio restart");
    end
    for (int k = 0; k < 10; k++) begin
      drive(1, 5, 6, k, 7, "R9 divider restart");
    end
    drive(1, 5, 6, 9, 40, "R9 settle");

    @(negedge clk);
    @(negedge clk);
    #2;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule